// File: doc/BRIEF.md
# Crate Event Builder Sequencer

The sequencer assembles one event record from every readout card in a crate and pushes it, one 16-bit word at a time, into an outbound event FIFO. A record opens with a header word carrying a running event number, continues with a fixed block of words from each card, and closes with a trailer word. Each card's block holds its hit pattern, sent as several words, followed by one beam-clock counter word. The sequencer checks that counter word against a reference count it captured when the event began.

Cards share one 16-bit data bus. The sequencer addresses one card at a time with a one-hot select and a single-cycle read strobe, then waits for that card's data-valid. If a card does not answer within a bounded number of cycles, it is marked missing. Its remaining words are filled with zeros, and a flag is raised in the trailer.

The outbound side is a valid/ready stream. `out_valid` is raised whenever a word is ready to send. The word and the valid stay unchanged until a cycle in which `out_ready` is also high; that cycle transfers exactly one word. Holding `out_ready` low only stalls the sequencer: no word is lost, repeated or reordered. A FIFO full flag drives `out_ready` as its inverse.

Top module: `crate_evt_builder`

## Requirements
- R1: While reset is applied and just after it ends, `out_valid`, `card_rd`, `busy` and every bit of `card_sel` are 0.
- R2: An event starts only when the sequencer is idle and every bit of `evt_avail` is 1. Its header word is `{4'hA, evt_num[11:0]}`. `evt_num` is 0 after reset and increases by one for each completed record.
- R3: After the header, cards are visited in ascending index order. Each card contributes exactly HIT_WORDS+1 words: the hit words first, then the beam-clock counter word, in the order the card supplied them.
- R4: Each word read from a card takes its own `card_rd` pulse, which lasts one cycle. While `card_rd` is high, `card_sel` is one-hot and names that card. At all times `card_sel` has at most one bit set.
- R5: A word is captured only in a cycle with `card_dv` high. A `card_dv` arriving in any of the first TIMEOUT cycles after the request is accepted. Bus contents without `card_dv` are ignored.
- R6: If no `card_dv` arrives within TIMEOUT cycles of a request, that word and all of the card's remaining words are written as 0x0000. No further `card_rd` pulses go to that card in this event, and trailer bit 14 is set.
- R7: The beam-clock counter word of each card is compared with `bclk_ref` as sampled at event start. Any mismatch sets trailer bit 15. Zero-filled words are not compared.
- R8: The trailer word is `{mismatch, missing, 2'b11, count[11:0]}`. The count is the total number of words in the record, header and trailer included: NCARD*(HIT_WORDS+1)+2.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays unchanged. A word is transferred exactly in each cycle where both are high.
- R10: `busy` is high from the start of an event until its trailer is accepted. A new event cannot start before that, even if `evt_avail` stays all ones. `out_valid` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_avail | input | NCARD | Per-card event-available flags |
| bclk_ref | input | DW | Reference beam-clock count, sampled at event start |
| card_sel | output | NCARD | One-hot card select during a read |
| card_rd | output | 1 | Single-cycle read request strobe |
| card_dv | input | 1 | Data-valid from the selected card |
| card_data | input | DW | Shared card data bus |
| out_valid | output | 1 | Outbound word valid |
| out_ready | input | 1 | Outbound FIFO can accept (inverse of full) |
| out_data | output | DW | Outbound word |
| busy | output | 1 | Event being built |

## Verification
The bound assertions watch the protocol rules that hold on every cycle:
- `out_valid` and `out_data` stay stable while stalled;
- `card_sel` is one-hot whenever `card_rd` is high, and at most one-hot otherwise;
- `card_rd` lasts only one cycle;
- a record starts only after every card's `evt_avail` is high;
- no output is offered while idle.

The bench scenarios cover what depends on content and counting. They compare whole records word by word against a model: card ordering, zero fill after a timeout at exactly the limit, acceptance of a reply on the last allowed cycle, mismatch and missing flags, the trailer word count, the event numbering, and how many read strobes each card received.

// File: rtl/ceb_pkg.sv
package ceb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_REQ,
    ST_WAIT,
    ST_DATA,
    ST_TRL
  } ceb_state_e;

  localparam logic [3:0] HDR_TAG = 4'hA;
  localparam logic [1:0] TRL_TAG = 2'b11;
endpackage

// File: rtl/ceb_sel_dec.sv
module ceb_sel_dec #(
  parameter int NCARD = 20,
  parameter int IW    = 5
) (
  input  logic [IW-1:0]    idx,
  input  logic             en,
  output logic [NCARD-1:0] sel
);
  for (genvar i = 0; i < NCARD; i++) begin : g_sel
    assign sel[i] = en && (idx == IW'(i));
  end
endmodule

// File: rtl/ceb_timer.sv
module ceb_timer #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [TW-1:0] cnt_q;

  assign expired = run && (cnt_q == TW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (run && !expired) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/ceb_fmt.sv
module ceb_fmt
  import ceb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [DW-5:0] evt_num,
  input  logic [DW-5:0] wcnt,
  input  logic          mm_flag,
  input  logic          miss_flag,
  output logic [DW-1:0] hdr_word,
  output logic [DW-1:0] trl_word
);
  localparam int CW = DW - 4;

  logic [CW-1:0] total;

  // the trailer counts itself
  assign total    = wcnt + CW'(1);
  assign hdr_word = {HDR_TAG, evt_num};
  assign trl_word = {mm_flag, miss_flag, TRL_TAG, total};
endmodule

// File: rtl/crate_evt_builder.sv
module crate_evt_builder
  import ceb_pkg::*;
#(
  parameter int NCARD     = 20,
  parameter int HIT_WORDS = 6,
  parameter int DW        = 16,
  parameter int TIMEOUT   = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCARD-1:0] evt_avail,
  input  logic [DW-1:0]    bclk_ref,
  output logic [NCARD-1:0] card_sel,
  output logic             card_rd,
  input  logic             card_dv,
  input  logic [DW-1:0]    card_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             busy
);
  localparam int WPC  = HIT_WORDS + 1;
  localparam int IW   = (NCARD > 1) ? $clog2(NCARD) : 1;
  localparam int WIW  = (WPC > 1) ? $clog2(WPC) : 1;
  localparam int CW   = DW - 4;
  localparam logic [WIW-1:0] LAST_WORD = WIW'(WPC - 1);
  localparam logic [IW-1:0]  LAST_CARD = IW'(NCARD - 1);

  ceb_state_e     state_q;
  logic [IW-1:0]  card_q;
  logic [WIW-1:0] word_q;
  logic           missing_q;
  logic           mm_q;
  logic           miss_q;
  logic [CW-1:0]  wcnt_q;
  logic [CW-1:0]  evt_q;
  logic [DW-1:0]  ref_q;
  logic [DW-1:0]  data_q;

  logic           tmr_clr;
  logic           tmr_run;
  logic           tmr_expired;
  logic           sel_en;
  logic [DW-1:0]  hdr_word;
  logic [DW-1:0]  trl_word;
  logic           push;

  assign sel_en  = ((state_q == ST_REQ) && !missing_q) || (state_q == ST_WAIT);
  assign card_rd = (state_q == ST_REQ) && !missing_q;
  assign tmr_clr = (state_q == ST_REQ);
  assign tmr_run = (state_q == ST_WAIT) && !card_dv;
  assign busy    = (state_q != ST_IDLE);

  ceb_sel_dec #(.NCARD(NCARD), .IW(IW)) u_sel (
    .idx (card_q),
    .en  (sel_en),
    .sel (card_sel)
  );

  ceb_timer #(.LIMIT(TIMEOUT)) u_tmr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  ceb_fmt #(.DW(DW)) u_fmt (
    .evt_num   (evt_q),
    .wcnt      (wcnt_q),
    .mm_flag   (mm_q),
    .miss_flag (miss_q),
    .hdr_word  (hdr_word),
    .trl_word  (trl_word)
  );

  // outbound stream mux
  always_comb begin
    out_valid = 1'b0;
    out_data  = '0;
    case (state_q)
      ST_HDR:  begin out_valid = 1'b1; out_data = hdr_word; end
      ST_DATA: begin out_valid = 1'b1; out_data = data_q;   end
      ST_TRL:  begin out_valid = 1'b1; out_data = trl_word; end
      default: ;
    endcase
  end

  assign push = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      card_q    <= '0;
      word_q    <= '0;
      missing_q <= 1'b0;
      mm_q      <= 1'b0;
      miss_q    <= 1'b0;
      wcnt_q    <= '0;
      evt_q     <= '0;
      ref_q     <= '0;
      data_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (&evt_avail) begin
            ref_q     <= bclk_ref;
            card_q    <= '0;
            word_q    <= '0;
            missing_q <= 1'b0;
            mm_q      <= 1'b0;
            miss_q    <= 1'b0;
            wcnt_q    <= '0;
            state_q   <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (push) begin
            wcnt_q  <= wcnt_q + 1'b1;
            state_q <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (missing_q) begin
            data_q  <= '0;
            state_q <= ST_DATA;
          end else begin
            state_q <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (card_dv) begin
            data_q <= card_data;
            if ((word_q == LAST_WORD) && (card_data != ref_q)) begin
              mm_q <= 1'b1;
            end
            state_q <= ST_DATA;
          end else if (tmr_expired) begin
            data_q    <= '0;
            missing_q <= 1'b1;
            miss_q    <= 1'b1;
            state_q   <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (push) begin
            wcnt_q <= wcnt_q + 1'b1;
            if (word_q == LAST_WORD) begin
              word_q    <= '0;
              missing_q <= 1'b0;
              if (card_q == LAST_CARD) begin
                state_q <= ST_TRL;
              end else begin
                card_q  <= card_q + 1'b1;
                state_q <= ST_REQ;
              end
            end else begin
              word_q  <= word_q + 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        ST_TRL: begin
          if (push) begin
            evt_q   <= evt_q + 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ceb_checker.sv
module ceb_checker #(
  parameter int NCARD = 20,
  parameter int DW    = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCARD-1:0] evt_avail,
  input logic [NCARD-1:0] card_sel,
  input logic             card_rd,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic             busy
);
  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R9

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data)); // R9

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(card_sel)); // R4

  AST_RD_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    card_rd |-> ($countones(card_sel) == 1)); // R4

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    card_rd |=> !card_rd); // R4

  AST_START_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(&evt_avail)); // R2

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid); // R10

  AST_RD_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    card_rd |-> !out_valid); // R3
endmodule

bind crate_evt_builder ceb_checker #(.NCARD(NCARD), .DW(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_avail (evt_avail),
  .card_sel  (card_sel),
  .card_rd   (card_rd),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .busy      (busy)
);

// File: tb/crate_evt_builder_bench.sv
module crate_evt_builder_bench;
  localparam int NC   = 3;
  localparam int HW   = 6;
  localparam int WPC  = HW + 1;
  localparam int TMO  = 8;
  localparam int RLEN = NC * WPC + 2;

  typedef struct packed {
    logic [15:0] bclk;
    logic [15:0] seed;
    logic [3:0]  lat;
    logic [3:0]  dead;   // card index + 1, 0 = none
    logic [3:0]  bad;    // card index + 1, 0 = none
    logic [3:0]  rmode;  // 0 always ready, 1 every third cycle, 2 pseudo-random
  } vec_t;

  localparam int NV = 5;
  localparam vec_t VEC [NV] = '{
    '{16'h1234, 16'h0001, 4'd0, 4'd0, 4'd0, 4'd0},
    '{16'h0BEE, 16'h7777, 4'd3, 4'd0, 4'd2, 4'd1},
    '{16'hFFFF, 16'h0102, 4'd7, 4'd0, 4'd0, 4'd2},
    '{16'h0042, 16'h3333, 4'd1, 4'd3, 4'd0, 4'd0},
    '{16'h00AA, 16'h9999, 4'd2, 4'd1, 4'd3, 4'd1}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NC-1:0] evt_avail;
  logic [15:0]   bclk_ref;
  logic [NC-1:0] card_sel;
  logic          card_rd;
  logic          card_dv;
  logic [15:0]   card_data;
  logic          out_valid;
  logic          out_ready;
  logic [15:0]   out_data;
  logic          busy;

  always #10 clk = ~clk;

  crate_evt_builder #(.NCARD(NC), .HIT_WORDS(HW), .DW(16), .TIMEOUT(TMO)) u_crate_evt_builder (
    .clk(clk), .rst_n(rst_n), .evt_avail(evt_avail), .bclk_ref(bclk_ref),
    .card_sel(card_sel), .card_rd(card_rd), .card_dv(card_dv), .card_data(card_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .busy(busy)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [15:0] mem [NC][WPC];
  int          lat_c [NC];
  int          ridx [NC];
  int          rdcnt [NC];
  logic [15:0] got [64];
  logic [15:0] expw [64];
  int          gcnt = 0;
  int          rmode = 0;
  int          cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          pend = 1'b0;
  int          pcard = 0;
  int          pcnt = 0;
  int          evt_no = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // card responder and stream sink, all on the falling edge
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    card_dv   = 1'b0;
    card_data = 16'hDEAD;
    if (pend) begin
      if (pcnt == 0) begin
        card_dv   = 1'b1;
        card_data = mem[pcard][ridx[pcard]];
        ridx[pcard] = (ridx[pcard] + 1) % WPC;
        pend = 1'b0;
      end else begin
        pcnt--;
      end
    end
    if (card_rd) begin
      for (int c = 0; c < NC; c++) begin
        if (card_sel[c]) begin
          pcard = c;
          rdcnt[c]++;
        end
      end
      pend = 1'b1;
      pcnt = lat_c[pcard];
    end
    case (rmode)
      1:       out_ready = (cyc % 3 == 0);
      2:       out_ready = lfsr[0];
      default: out_ready = 1'b1;
    endcase
    if (out_valid && out_ready && gcnt < 64) begin
      got[gcnt] = out_data;
      gcnt++;
    end
  end

  task automatic setup(vec_t v);
    for (int c = 0; c < NC; c++) begin
      for (int w = 0; w < HW; w++) begin
        mem[c][w] = (v.seed + 16'(c) * 16'h0101 + 16'(w) * 16'h1111) ^ 16'h5A5A;
      end
      mem[c][HW] = (int'(v.bad) == c + 1) ? (v.bclk ^ 16'h0004) : v.bclk;
      lat_c[c]   = (int'(v.dead) == c + 1) ? TMO : int'(v.lat);
      ridx[c]    = 0;
      rdcnt[c]   = 0;
    end
    rmode    = int'(v.rmode);
    bclk_ref = v.bclk;
  endtask

  // expected record at offset base for event number en
  task automatic build_exp(vec_t v, int base, int en);
    logic mm;
    logic miss;
    mm   = (v.bad != 0) && (v.bad != v.dead);
    miss = (v.dead != 0);
    expw[base] = {4'hA, 12'(en)};
    for (int c = 0; c < NC; c++) begin
      for (int w = 0; w < WPC; w++) begin
        expw[base + 1 + c * WPC + w] = (int'(v.dead) == c + 1) ? 16'h0000 : mem[c][w];
      end
    end
    expw[base + RLEN - 1] = {mm, miss, 2'b11, 12'(RLEN)};
  endtask

  task automatic wait_words(int n);
    int lim;
    lim = 0;
    while (gcnt < n && lim < 5000) begin
      @(posedge clk);
      lim++;
    end
    if (gcnt < n) chk("R3", "record length (hang)", 32'(gcnt), 32'(n));
  endtask

  task automatic wait_busy();
    int lim;
    lim = 0;
    while (!busy && lim < 100) begin
      @(posedge clk);
      lim++;
    end
    chk("R2", "event started", 32'(busy), 32'd1);
  endtask

  task automatic compare_record(int base, string tag);
    int bad;
    bad = 0;
    chk("R2", {tag, " header"}, 32'(got[base]), 32'(expw[base]));
    for (int i = 1; i < RLEN - 1; i++) begin
      if (got[base + i] !== expw[base + i]) begin
        bad++;
        $display("  word %0d: actual %h expected %h", i, got[base + i], expw[base + i]);
      end
    end
    chk("R3 R5 R6", {tag, " card words differing"}, 32'(bad), 32'd0);
    chk("R7 R8", {tag, " trailer"}, 32'(got[base + RLEN - 1]), 32'(expw[base + RLEN - 1]));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    rst_n     = 1'b0;
    evt_avail = '0;
    bclk_ref  = '0;
    out_ready = 1'b1;
    card_dv   = 1'b0;
    card_data = 16'hDEAD;
    for (int c = 0; c < NC; c++) begin
      lat_c[c] = 0; ridx[c] = 0; rdcnt[c] = 0;
      for (int w = 0; w < WPC; w++) mem[c][w] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "out_valid after reset", 32'(out_valid), 32'd0);
    chk("R1", "card_rd after reset", 32'(card_rd), 32'd0);
    chk("R1", "card_sel after reset", 32'(card_sel), 32'd0);
    chk("R1", "busy after reset", 32'(busy), 32'd0);

    // R2: one card not ready -> no event
    gcnt = 0;
    evt_avail = 3'b011;
    repeat (20) @(negedge clk);
    chk("R2", "busy with partial avail", 32'(busy), 32'd0);
    chk("R2", "words with partial avail", 32'(gcnt), 32'd0);
    evt_avail = '0;

    // table-driven events
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i]);
      build_exp(VEC[i], 0, evt_no);
      gcnt = 0;
      @(negedge clk);
      evt_avail = '1;
      wait_busy();
      @(negedge clk);
      evt_avail = '0;
      wait_words(RLEN);
      repeat (4) @(negedge clk);
      compare_record(0, $sformatf("vec%0d", i));
      for (int c = 0; c < NC; c++) begin
        chk("R4 R6", $sformatf("vec%0d card%0d read strobes", i, c), 32'(rdcnt[c]),
            (int'(VEC[i].dead) == c + 1) ? 32'd1 : 32'(WPC));
      end
      chk("R10", $sformatf("vec%0d busy after trailer", i), 32'(busy), 32'd0);
      chk("R9", $sformatf("vec%0d no extra words", i), 32'(gcnt), 32'(RLEN));
      evt_no++;
    end

    // R10: avail held high, two records strictly back to back
    setup(VEC[0]);
    rmode = 1;
    build_exp(VEC[0], 0, evt_no);
    build_exp(VEC[0], RLEN, evt_no + 1);
    gcnt = 0;
    @(negedge clk);
    evt_avail = '1;
    wait_words(RLEN + 1);
    @(negedge clk);
    evt_avail = '0;
    wait_words(2 * RLEN);
    repeat (4) @(negedge clk);
    compare_record(0, "r10_first");
    compare_record(RLEN, "r10_second");
    chk("R10", "total words two events", 32'(gcnt), 32'(2 * RLEN));
    chk("R10", "idle after two events", 32'(busy), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule